// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block is the programming port of a frequency-synthesizer control block. An external controller drives three lines: a serial clock, a data line and a strobe. Each word has 24 bits and is shifted in most significant bit first. When the strobe rises, the block reads the address held in the lowest bits of the word. It then copies the payload into one of the parallel configuration registers, provided exactly 24 serial clocks were seen since the previous strobe. While the strobe is high, the shift register is frozen.

All three serial lines are oversampled in the system clock domain. Each passes through a two-flop synchroniser, and edges are detected after it. The compensation byte carried by the B word is not applied at once. It waits in a holding register and moves to the active compensation output in the same cycle that an A word loads the main divider ratio. The divider and its compensation therefore always change together. Each accepted word raises a one-cycle pulse that identifies which register it loaded.

Top module: `cfg_serial_loader`

## Requirements
- R1: After a synchronous reset, every parallel output and the holding register are zero, and no update pulse is high.
- R2: Serial data is sampled on each rising edge of the serial clock, most significant bit first. After 24 bits, bits [1:0] of the word are the address: 00 selects the A word, 01 the B word and 10 the C word. With 11, bit 2 also takes part in the address: 011 selects the D word and 111 is reserved.
- R3: An accepted A word loads div_ratio from bits [23:2]. In the same cycle it copies the holding register to comp_act and raises commit_pulse for one cycle.
- R4: An accepted B word loads ref_div from bits [15:2] and pulses upd_ref. It stores bits [23:16] in the holding register only, so comp_act does not change until the next A word.
- R5: An accepted C word loads ctrl_word from bits [23:2] and pulses upd_ctrl.
- R6: An accepted D word loads test_word from bits [23:3] and pulses upd_test. A reserved word (address 111) changes no output and raises no pulse.
- R7: A strobe that follows any count of serial clocks other than exactly 24 is discarded: no output changes and no pulse is raised.
- R8: Serial clock edges that occur while the strobe is high neither shift nor count. The bit count restarts from zero for the word that follows the strobe.
- R9: Each accepted word raises exactly one pulse, for one system clock cycle. At most one pulse is high at a time, and a register output changes only in a cycle where its own pulse is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial programming clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_strobe | input | 1 | Latch strobe; rising edge loads the word |
| div_ratio | output | 22 | Main divider ratio (A word) |
| comp_act | output | 8 | Active compensation byte, committed by A word |
| ref_div | output | 14 | Reference divider (B word) |
| ctrl_word | output | 22 | Control and enable bits (C word) |
| test_word | output | 21 | Test settings (D word) |
| commit_pulse | output | 1 | One-cycle pulse on divider and compensation commit |
| upd_ref | output | 1 | One-cycle pulse on B word load |
| upd_ctrl | output | 1 | One-cycle pulse on C word load |
| upd_test | output | 1 | One-cycle pulse on D word load |

## Verification
The hardest case to reach from the ports is a serial clock that toggles while the strobe is high. In a correct design it has no visible effect. A wrong design only shows the error later, when the next word is miscounted and therefore dropped. To reach it, the stimulus first sends a short word and strobes it. It then pulses the serial clock four times with the strobe still high, and after that sends a full word that must be accepted. Separately, the bench stages a compensation byte with a B word and checks that comp_act keeps its old value across later C and D words, until an A word commits it. Random traffic mixes all word types with wrong bit counts.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int WORD_W = 24;
    localparam int ADDR_W = 2;
    localparam int DIV_W  = WORD_W - ADDR_W;
    localparam int COMP_W = 8;
    localparam int REF_W  = WORD_W - ADDR_W - COMP_W;
    localparam int CTRL_W = WORD_W - ADDR_W;
    localparam int TEST_W = WORD_W - ADDR_W - 1;
    localparam int CNT_W  = $clog2(WORD_W + 2);

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_DIV  = 3'd1,
        K_COMP = 3'd2,
        K_CTRL = 3'd3,
        K_TEST = 3'd4
    } word_kind_t;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [COMP_W-1:0] comp;
        logic [REF_W-1:0]  refd;
        logic [CTRL_W-1:0] ctrl;
        logic [TEST_W-1:0] test;
    } cfg_regs_t;

    function automatic word_kind_t word_kind(input logic [WORD_W-1:0] w);
        word_kind_t k;
        unique case (w[1:0])
            2'b00:   k = K_DIV;
            2'b01:   k = K_COMP;
            2'b10:   k = K_CTRL;
            default: k = w[2] ? K_NONE : K_TEST;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], async_in[b]};
        end
        assign lvl[b] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter
    import cfgl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              hold,
    input  logic              din,
    output logic [WORD_W-1:0] sr,
    output logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            cnt <= '0;
        end else if (hold) begin
            cnt <= '0;
        end else if (shift_en) begin
            sr <= {sr[WORD_W-2:0], din};
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cfgl_regbank.sv
module cfgl_regbank
    import cfgl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output cfg_regs_t         regs,
    output logic [COMP_W-1:0] staged,
    output logic              commit_pulse,
    output logic              upd_ref,
    output logic              upd_ctrl,
    output logic              upd_test
);
    word_kind_t kind;
    assign kind = word_kind(word);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs         <= '0;
            staged       <= '0;
            commit_pulse <= 1'b0;
            upd_ref      <= 1'b0;
            upd_ctrl     <= 1'b0;
            upd_test     <= 1'b0;
        end else begin
            commit_pulse <= 1'b0;
            upd_ref      <= 1'b0;
            upd_ctrl     <= 1'b0;
            upd_test     <= 1'b0;
            if (load) begin
                unique case (kind)
                    K_DIV: begin
                        regs.div     <= word[WORD_W-1:ADDR_W];
                        regs.comp    <= staged;
                        commit_pulse <= 1'b1;
                    end
                    K_COMP: begin
                        staged    <= word[WORD_W-1:WORD_W-COMP_W];
                        regs.refd <= word[ADDR_W+REF_W-1:ADDR_W];
                        upd_ref   <= 1'b1;
                    end
                    K_CTRL: begin
                        regs.ctrl <= word[WORD_W-1:ADDR_W];
                        upd_ctrl  <= 1'b1;
                    end
                    K_TEST: begin
                        regs.test <= word[WORD_W-1:ADDR_W+1];
                        upd_test  <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfgl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_strobe,
    output logic [DIV_W-1:0]  div_ratio,
    output logic [COMP_W-1:0] comp_act,
    output logic [REF_W-1:0]  ref_div,
    output logic [CTRL_W-1:0] ctrl_word,
    output logic [TEST_W-1:0] test_word,
    output logic              commit_pulse,
    output logic              upd_ref,
    output logic              upd_ctrl,
    output logic              upd_test
);
    localparam int IDX_CLK = 0;
    localparam int IDX_DAT = 1;
    localparam int IDX_STB = 2;

    logic [2:0]        s_lvl, s_rise;
    logic              shift_en, load;
    logic [WORD_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [COMP_W-1:0] staged_q;
    cfg_regs_t         regs_q;

    cfgl_sync #(.W(3), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ser_strobe, ser_data, ser_clk}),
        .lvl      (s_lvl),
        .rise     (s_rise)
    );

    assign shift_en = s_rise[IDX_CLK] & ~s_lvl[IDX_STB];

    cfgl_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .hold     (s_lvl[IDX_STB]),
        .din      (s_lvl[IDX_DAT]),
        .sr       (sr_q),
        .cnt      (cnt_q)
    );

    assign load = s_rise[IDX_STB] && (cnt_q == CNT_W'(WORD_W));

    cfgl_regbank u_regs (
        .clk          (clk),
        .rst          (rst),
        .load         (load),
        .word         (sr_q),
        .regs         (regs_q),
        .staged       (staged_q),
        .commit_pulse (commit_pulse),
        .upd_ref      (upd_ref),
        .upd_ctrl     (upd_ctrl),
        .upd_test     (upd_test)
    );

    assign div_ratio = regs_q.div;
    assign comp_act  = regs_q.comp;
    assign ref_div   = regs_q.refd;
    assign ctrl_word = regs_q.ctrl;
    assign test_word = regs_q.test;
endmodule

// File: rtl/cfgl_chk.sv
module cfgl_chk
    import cfgl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              strobe_lvl,
    input logic [WORD_W-1:0] sr,
    input logic [CNT_W-1:0]  cnt,
    input logic [COMP_W-1:0] staged,
    input logic [DIV_W-1:0]  div_ratio,
    input logic [COMP_W-1:0] comp_act,
    input logic [REF_W-1:0]  ref_div,
    input logic [CTRL_W-1:0] ctrl_word,
    input logic [TEST_W-1:0] test_word,
    input logic              commit_pulse,
    input logic              upd_ref,
    input logic              upd_ctrl,
    input logic              upd_test
);
    // R8: frozen shift register while strobe is high
    a_r8_frozen_shift: assert property (@(posedge clk) disable iff (rst)
        strobe_lvl |=> $stable(sr));

    // R8: count restarts while strobe is high
    a_r8_count_cleared: assert property (@(posedge clk) disable iff (rst)
        strobe_lvl |=> (cnt == '0));

    // R7: counter stays within saturation limit
    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(WORD_W + 1));

    // R9: at most one pulse at a time
    a_r9_onehot_pulse: assert property (@(posedge clk) disable iff (rst)
        $onehot0({commit_pulse, upd_ref, upd_ctrl, upd_test}));

    // R9: pulses last one cycle
    a_r9_pulse_width: assert property (@(posedge clk) disable iff (rst)
        (commit_pulse | upd_ref | upd_ctrl | upd_test) |=>
        !(commit_pulse | upd_ref | upd_ctrl | upd_test));

    // R3: committed compensation equals held byte
    a_r3_commit_value: assert property (@(posedge clk) disable iff (rst)
        $rose(commit_pulse) |-> (comp_act == $past(staged)));

    // R3: divider and compensation move only on commit
    a_r3_div_on_commit: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_ratio) |-> commit_pulse);

    // R4: active compensation changes only with a commit
    a_r4_comp_on_commit: assert property (@(posedge clk) disable iff (rst)
        !$stable(comp_act) |-> commit_pulse);

    // R4: reference divider changes only with its pulse
    a_r4_ref_on_pulse: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_div) |-> upd_ref);

    // R5: control word changes only with its pulse
    a_r5_ctrl_on_pulse: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_word) |-> upd_ctrl);

    // R6: test word changes only with its pulse
    a_r6_test_on_pulse: assert property (@(posedge clk) disable iff (rst)
        !$stable(test_word) |-> upd_test);
endmodule

bind cfg_serial_loader cfgl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .strobe_lvl   (s_lvl[2]),
    .sr           (sr_q),
    .cnt          (cnt_q),
    .staged       (staged_q),
    .div_ratio    (div_ratio),
    .comp_act     (comp_act),
    .ref_div      (ref_div),
    .ctrl_word    (ctrl_word),
    .test_word    (test_word),
    .commit_pulse (commit_pulse),
    .upd_ref      (upd_ref),
    .upd_ctrl     (upd_ctrl),
    .upd_test     (upd_test)
);

// File: tb/sim_cfg_serial_loader.sv
module sim_cfg_serial_loader;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0;
    logic [21:0] div_ratio;
    logic [7:0]  comp_act;
    logic [13:0] ref_div;
    logic [21:0] ctrl_word;
    logic [20:0] test_word;
    logic commit_pulse, upd_ref, upd_ctrl, upd_test;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int n_commit = 0, n_ref = 0, n_ctrl = 0, n_test = 0;
    int p_commit, p_ref, p_ctrl, p_test;

    logic [21:0] e_div;
    logic [7:0]  e_comp, e_stage;
    logic [13:0] e_ref;
    logic [21:0] e_ctrl;
    logic [20:0] e_test;

    cfg_serial_loader u0 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_strobe(ser_strobe), .div_ratio(div_ratio), .comp_act(comp_act),
        .ref_div(ref_div), .ctrl_word(ctrl_word), .test_word(test_word),
        .commit_pulse(commit_pulse), .upd_ref(upd_ref), .upd_ctrl(upd_ctrl),
        .upd_test(upd_test)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (commit_pulse) n_commit++;
        if (upd_ref)      n_ref++;
        if (upd_ctrl)     n_ctrl++;
        if (upd_test)     n_test++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [23:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            ser_data = (i < 24) ? w[23 - i] : 1'($urandom_range(0, 1));
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
        wait_clk(4);
    endtask

    task automatic strobe(input int extra_clks);
        ser_strobe = 1'b1;
        wait_clk(8);
        for (int i = 0; i < extra_clks; i++) begin
            ser_clk = 1'b1; wait_clk(4); ser_clk = 1'b0; wait_clk(4);
        end
        ser_strobe = 1'b0;
        wait_clk(6);
    endtask

    function automatic int kind_of(input logic [23:0] w);
        if (w[1:0] == 2'b00) return 1;
        if (w[1:0] == 2'b01) return 2;
        if (w[1:0] == 2'b10) return 3;
        return w[2] ? 0 : 4;
    endfunction

    function automatic string tag_of(input int k, input int n);
        if (n != 24) return "R7";
        case (k)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic model(input logic [23:0] w, input int n);
        if (n != 24) return;
        case (kind_of(w))
            1: begin e_div = w[23:2]; e_comp = e_stage; p_commit++; end
            2: begin e_stage = w[23:16]; e_ref = w[15:2]; p_ref++; end
            3: begin e_ctrl = w[23:2]; p_ctrl++; end
            4: begin e_test = w[23:3]; p_test++; end
            default: ;
        endcase
    endtask

    task automatic check_all(input string tag);
        check({tag, " div_ratio"}, 32'(div_ratio), 32'(e_div));
        check({tag, " comp_act"},  32'(comp_act),  32'(e_comp));
        check({tag, " ref_div"},   32'(ref_div),   32'(e_ref));
        check({tag, " ctrl_word"}, 32'(ctrl_word), 32'(e_ctrl));
        check({tag, " test_word"}, 32'(test_word), 32'(e_test));
        check({tag, " R9 commit count"}, 32'(n_commit), 32'(p_commit));
        check({tag, " R9 ref count"},    32'(n_ref),    32'(p_ref));
        check({tag, " R9 ctrl count"},   32'(n_ctrl),   32'(p_ctrl));
        check({tag, " R9 test count"},   32'(n_test),   32'(p_test));
    endtask

    task automatic xfer(input logic [23:0] w, input int n, input string tag);
        send_bits(w, n);
        strobe(0);
        model(w, n);
        check_all(tag);
    endtask

    initial begin
        e_div = '0; e_comp = '0; e_stage = '0; e_ref = '0; e_ctrl = '0; e_test = '0;
        p_commit = 0; p_ref = 0; p_ctrl = 0; p_test = 0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        check_all("R1 reset");

        xfer({22'h2ABCDE, 2'b00}, 24, "R3 first divider");
        xfer({8'hA5, 14'h1234, 2'b01}, 24, "R4 stage");
        check("R4 comp held after B", 32'(comp_act), 32'h0);
        xfer({22'h155555, 2'b10}, 24, "R5 control");
        xfer({21'h0F0F0F, 3'b011}, 24, "R6 test");
        check("R4 comp still held", 32'(comp_act), 32'h0);
        xfer({22'h000101, 2'b00}, 24, "R3 commit");
        check("R3 comp committed", 32'(comp_act), 32'hA5);
        xfer({21'h1FFFFF, 3'b111}, 24, "R6 reserved");
        xfer({22'h3FFFFF, 2'b10}, 23, "R7 short");
        xfer({22'h3FFFFF, 2'b10}, 25, "R7 long");
        xfer({22'h000000, 2'b10}, 0, "R7 empty");
        xfer({24'h800001}, 24, "R2 msb first");
        check("R2 ref bit", 32'(ref_div), 32'h0);
        check("R2 staged via commit", 32'(comp_act), 32'hA5);
        xfer({22'h000003, 2'b00}, 24, "R2 commit of msb word");
        check("R2 msb landed in comp", 32'(comp_act), 32'h80);

        send_bits(24'hFFFFFE, 20);
        strobe(4);
        check_all("R8 short word then clocks under strobe");
        xfer({22'h2468AC, 2'b10}, 24, "R8 word after ignored clocks");

        for (int t = 0; t < 260; t++) begin
            logic [23:0] w;
            int n;
            w = 24'($urandom);
            n = ($urandom_range(0, 9) == 0) ? $urandom_range(20, 27) : 24;
            xfer(w, n, tag_of(kind_of(w), n));
        end

        done = 1'b1;
    end

    initial begin
        void'($urandom(32'd1234));
        fork
            begin wait (done); end
            begin
                repeat (190000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired R9 actual=timeout expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule